// File: doc/BRIEF.md
# Tapped Delay Registered Input

This block conditions one input pin before it reaches an internal line. The pin value is shifted through a chain of edge-triggered stages, seven by default. A tap selector picks either the raw pin value or the output of one of the stages. The picked value, optionally inverted, is captured in a final register that drives the internal line. The result is a delay of 0 to `STAGES` clocks in front of a fixed one-clock capture.

The tap index, the inversion flag, the active clock edge and the polarities of the clock enable and the input enable are configuration inputs. They are held static by whatever stores them. The clock enable freezes the whole path when it is inactive. The input enable forces the line low and clears its valid flag without stopping the shift chain. The stages carry no reset, so their contents are undefined until `STAGES` active edges have passed. Only the final register and the valid flag are reset.

Top module: `tapdly_in`

## Requirements
- R1: While the clock enable is active, each active clock edge moves the pin value into stage 1 and the content of stage i into stage i+1, for i from 1 to STAGES-1.
- R2: `cfg_tap` = k selects the raw pin value for k = 0 and stage k for 1 ≤ k ≤ STAGES. With the clock enable held active, a pin value present before active edge e appears on `line_q` right after edge e+k, which is k+1 active edges counted from e.
- R3: When `cfg_inv` = 1, `line_q` carries the complement of the selected tap value. When `cfg_inv` = 0, it carries the true value.
- R4: While the clock enable is inactive and the input enable is active, neither the stages nor `line_q`/`line_vld` change at an active edge. Pin values present during that time never enter the chain.
- R5: At any active edge where the input enable is inactive, `line_q` becomes 0 and `line_vld` becomes 0, whatever the state of the clock enable. While the clock enable stays active, the stages keep shifting. At an active edge where both enables are active, `line_vld` becomes 1.
- R6: `cfg_fall` = 0 makes the rising edge of `clk` the active edge. `cfg_fall` = 1 makes the falling edge the active edge. The other edge changes nothing.
- R7: The clock enable is active when `cke` differs from `cfg_cke_low`, so `cfg_cke_low` = 1 means active-low. The input enable is active when `ie` differs from `cfg_ie_low`.
- R8: An active edge with `rst` = 1 clears `line_q` and `line_vld` to 0. The stages are not reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the active edge is chosen by `cfg_fall` |
| rst | input | 1 | Synchronous active-high reset of the output register |
| cfg_tap | input | TAP_W | Tap index, 0 = raw pin, k = stage k |
| cfg_inv | input | 1 | 1 = drive the complement of the selected tap |
| cfg_fall | input | 1 | 1 = falling edge is active, 0 = rising edge |
| cfg_cke_low | input | 1 | 1 = clock enable is active-low |
| cfg_ie_low | input | 1 | 1 = input enable is active-low |
| pin | input | 1 | Pin value entering the chain |
| cke | input | 1 | Clock enable |
| ie | input | 1 | Input enable |
| line_q | output | 1 | Registered value driven to the internal line |
| line_vld | output | 1 | 1 while `line_q` holds a captured tap value |

## Verification
The bench measures the edge count from a pin step to the line for every tap. An off-by-one tap decode, or a missing or extra output register, shows up there as a latency that is one short or one long. It freezes the chain while toggling the pin and then releases it. A design that lets the chain shift, or lets frozen pin values in, would raise the line too early or at the wrong edge. It turns the input enable off while the chain runs and also while the clock enable is inactive. This catches a design that stops shifting under a disabled input, and one that fails to clear the line while frozen. It also runs with the falling edge and with inverted enable polarities, which catches a design that captures on the wrong clock phase or misreads the polarity settings.

// File: rtl/tapdly_pkg.sv
package tapdly_pkg;

  // Static path configuration, grouped for passing between submodules.
  typedef struct packed {
    logic inv;
    logic fall;
    logic cke_low;
    logic ie_low;
  } tap_mode_t;

  // An enable is active when the raw level differs from the low-active flag.
  function automatic logic level_active(input logic raw, input logic low_act);
    return raw ^ low_act;
  endfunction

endpackage

// File: rtl/tapdly_shift.sv
module tapdly_shift #(
  parameter int STAGES = 7
) (
  input  logic              clk,
  input  logic              en,
  input  logic              din,
  output logic [STAGES:0]   taps
);

  logic [STAGES:1] stage;

  assign taps[0] = din;

  // No reset on the stages, so a shift-register primitive can be inferred.
  for (genvar i = 1; i <= STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (en) stage[i] <= taps[i-1];
    end
    assign taps[i] = stage[i];
  end

endmodule

// File: rtl/tapdly_mux.sv
module tapdly_mux #(
  parameter int STAGES = 7,
  parameter int TAP_W  = $clog2(STAGES + 1)
) (
  input  logic [STAGES:0]    taps,
  input  logic [TAP_W-1:0]   sel,
  output logic               y
);

  localparam int NSEL = 1 << TAP_W;

  if (NSEL == STAGES + 1) begin : g_exact
    // Every index code names a tap.
    assign y = taps[sel];
  end else begin : g_clamp
    // Codes beyond the last stage select the last stage.
    logic [TAP_W-1:0] sel_c;
    always_comb begin
      sel_c = (sel > TAP_W'(STAGES)) ? TAP_W'(STAGES) : sel;
    end
    assign y = taps[sel_c];
  end

endmodule

// File: rtl/tapdly_outreg.sv
module tapdly_outreg (
  input  logic clk,
  input  logic rst,
  input  logic cke_act,
  input  logic ie_act,
  input  logic d,
  input  logic inv,
  output logic q,
  output logic vld
);

  // Input enable takes priority over clock enable: a disabled input
  // clears the line even while the path is frozen.
  always_ff @(posedge clk) begin
    if (rst) begin
      q   <= 1'b0;
      vld <= 1'b0;
    end else if (!ie_act) begin
      q   <= 1'b0;
      vld <= 1'b0;
    end else if (cke_act) begin
      q   <= d ^ inv;
      vld <= 1'b1;
    end
  end

endmodule

// File: rtl/tapdly_in.sv
module tapdly_in #(
  parameter int STAGES = 7,
  parameter int TAP_W  = $clog2(STAGES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TAP_W-1:0]  cfg_tap,
  input  logic              cfg_inv,
  input  logic              cfg_fall,
  input  logic              cfg_cke_low,
  input  logic              cfg_ie_low,
  input  logic              pin,
  input  logic              cke,
  input  logic              ie,
  output logic              line_q,
  output logic              line_vld
);
  import tapdly_pkg::*;

  tap_mode_t       mode;
  logic            clk_int;
  logic            cke_act;
  logic            ie_act;
  logic [STAGES:0] taps;
  logic            tap_sel;

  assign mode = '{inv: cfg_inv, fall: cfg_fall,
                  cke_low: cfg_cke_low, ie_low: cfg_ie_low};

  // Static edge select: inverting the clock makes the falling edge active.
  assign clk_int = clk ^ mode.fall;
  assign cke_act = level_active(cke, mode.cke_low);
  assign ie_act  = level_active(ie,  mode.ie_low);

  tapdly_shift #(.STAGES(STAGES)) u_shift (
    .clk  (clk_int),
    .en   (cke_act),
    .din  (pin),
    .taps (taps)
  );

  tapdly_mux #(.STAGES(STAGES), .TAP_W(TAP_W)) u_mux (
    .taps (taps),
    .sel  (cfg_tap),
    .y    (tap_sel)
  );

  tapdly_outreg u_out (
    .clk     (clk_int),
    .rst     (rst),
    .cke_act (cke_act),
    .ie_act  (ie_act),
    .d       (tap_sel),
    .inv     (mode.inv),
    .q       (line_q),
    .vld     (line_vld)
  );

endmodule

// File: rtl/tapdly_chk.sv
module tapdly_chk #(
  parameter int TAP_W = 3
) (
  input logic             clk_int,
  input logic             rst,
  input logic [TAP_W-1:0] cfg_tap,
  input logic             cfg_inv,
  input logic             cfg_cke_low,
  input logic             cfg_ie_low,
  input logic             pin,
  input logic             cke,
  input logic             ie,
  input logic             line_q,
  input logic             line_vld
);

  logic ie_on;
  logic cke_on;
  assign ie_on  = ie  ^ cfg_ie_low;
  assign cke_on = cke ^ cfg_cke_low;

  // R8: reset clears the line and its valid flag
  p_reset_clear_r8: assert property (@(posedge clk_int)
    rst |=> (!line_q && !line_vld));

  // R5: disabled input forces the line low and invalid
  p_ie_gate_r5: assert property (@(posedge clk_int) disable iff (rst)
    !ie_on |=> (!line_q && !line_vld));

  // R4: inactive clock enable freezes the output register
  p_cke_hold_r4: assert property (@(posedge clk_int) disable iff (rst)
    (ie_on && !cke_on) |=> ($stable(line_q) && $stable(line_vld)));

  // R2: tap 0 captures the pin at the same edge
  p_tap0_true_r2: assert property (@(posedge clk_int) disable iff (rst)
    (ie_on && cke_on && cfg_tap == '0 && !cfg_inv) |=>
      (line_q == $past(pin) && line_vld));

  // R3: inverted tap 0 captures the complement
  p_tap0_inv_r3: assert property (@(posedge clk_int) disable iff (rst)
    (ie_on && cke_on && cfg_tap == '0 && cfg_inv) |=>
      (line_q == !$past(pin)));

endmodule

bind tapdly_in tapdly_chk #(.TAP_W(TAP_W)) u_chk (
  .clk_int     (clk_int),
  .rst         (rst),
  .cfg_tap     (cfg_tap),
  .cfg_inv     (cfg_inv),
  .cfg_cke_low (cfg_cke_low),
  .cfg_ie_low  (cfg_ie_low),
  .pin         (pin),
  .cke         (cke),
  .ie          (ie),
  .line_q      (line_q),
  .line_vld    (line_vld)
);

// File: tb/sim_tapdly_in.sv
`timescale 1ns/1ps
module sim_tapdly_in;
  localparam int STAGES = 7;
  localparam int TAP_W  = $clog2(STAGES + 1);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst = 1'b1;
  logic [TAP_W-1:0] cfg_tap = '0;
  logic             cfg_inv = 1'b0, cfg_fall = 1'b0;
  logic             cfg_cke_low = 1'b0, cfg_ie_low = 1'b0;
  logic             pin = 1'b0, cke = 1'b1, ie = 1'b1;
  logic             line_q, line_vld;

  int checks = 0;
  int failures = 0;

  tapdly_in #(.STAGES(STAGES)) u0 (
    .clk(clk), .rst(rst), .cfg_tap(cfg_tap), .cfg_inv(cfg_inv),
    .cfg_fall(cfg_fall), .cfg_cke_low(cfg_cke_low), .cfg_ie_low(cfg_ie_low),
    .pin(pin), .cke(cke), .ie(ie), .line_q(line_q), .line_vld(line_vld)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Advance to just after the next active edge.
  task automatic tick();
    if (cfg_fall) @(negedge clk); else @(posedge clk);
    #1;
  endtask

  task automatic fill(input logic v);
    pin = v;
    repeat (STAGES + 1) tick();
  endtask

  task automatic t_reset();
    rst = 1'b1; pin = 1'b1; cke = 1'b1; ie = 1'b1;
    repeat (3) tick();
    chk(line_q == 1'b0, "R8 line_q in reset", line_q, 0);
    chk(line_vld == 1'b0, "R8 line_vld in reset", line_vld, 0);
    rst = 1'b0;
    tick();
    chk(line_vld == 1'b1, "R5 vld after first capture", line_vld, 1);
    chk(line_q == 1'b1, "R2 tap0 captures pin", line_q, 1);
  endtask

  task automatic t_latency();
    for (int k = 0; k <= STAGES; k++) begin
      int n;
      bit found;
      cfg_tap = TAP_W'(k);
      fill(1'b0);
      pin = 1'b1;
      n = 0; found = 1'b0;
      for (int i = 1; i <= STAGES + 4; i++) begin
        tick();
        if (!found && line_q) begin found = 1'b1; n = i; end
      end
      chk(n == k + 1, $sformatf("R2 latency tap %0d", k), n, k + 1);
      pin = 1'b0;
    end
  endtask

  task automatic t_pattern(input int k, input logic inv);
    logic [31:0] seq;
    int bad;
    seq = 32'hB4E1_9A37 ^ (32'h1357_2468 << k);
    cfg_tap = TAP_W'(k);
    cfg_inv = inv;
    fill(1'b0);
    bad = 0;
    for (int j = 0; j < 32; j++) begin
      logic e;
      pin = seq[j];
      tick();
      e = ((j >= k) ? seq[j - k] : 1'b0) ^ inv;
      if (line_q !== e) bad++;
    end
    chk(bad == 0, $sformatf("R1 R3 pattern tap %0d inv %0d mismatches", k, inv), bad, 0);
    cfg_inv = 1'b0;
  endtask

  task automatic t_hold();
    cfg_tap = TAP_W'(2);
    fill(1'b0);
    pin = 1'b1; tick();
    pin = 1'b0; cke = 1'b0;
    begin
      int moved;
      moved = 0;
      for (int i = 0; i < 5; i++) begin
        pin = (i == 1 || i == 2);
        tick();
        if (line_q !== 1'b0 || line_vld !== 1'b1) moved++;
      end
      chk(moved == 0, "R4 output frozen while cke inactive", moved, 0);
    end
    pin = 1'b0; cke = 1'b1;
    tick(); chk(line_q == 1'b0, "R4 first edge after release", line_q, 0);
    tick(); chk(line_q == 1'b1, "R4 held bit resumes", line_q, 1);
    tick(); chk(line_q == 1'b0, "R4 frozen pin values not captured", line_q, 0);
  endtask

  task automatic t_ie();
    cfg_tap = TAP_W'(3);
    fill(1'b0);
    ie = 1'b0; pin = 1'b1;
    tick();
    chk(line_q == 1'b0 && line_vld == 1'b0, "R5 ie off clears line", {line_q, line_vld}, 0);
    pin = 1'b0;
    tick(); tick();
    chk(line_vld == 1'b0, "R5 vld stays clear", line_vld, 0);
    ie = 1'b1;
    tick();
    chk(line_q == 1'b1 && line_vld == 1'b1, "R5 chain kept shifting", {line_q, line_vld}, 3);
    cfg_tap = '0; pin = 1'b1; tick();
    cke = 1'b0; ie = 1'b0;
    tick();
    chk(line_q == 1'b0 && line_vld == 1'b0, "R5 ie off wins over frozen cke", {line_q, line_vld}, 0);
    cke = 1'b1; ie = 1'b1; pin = 1'b0;
    tick();
  endtask

  task automatic t_polarity();
    cfg_tap = '0;
    cfg_cke_low = 1'b1; cke = 1'b0; pin = 1'b1;
    tick();
    chk(line_q == 1'b1, "R7 active-low cke captures", line_q, 1);
    pin = 1'b0; cke = 1'b1;
    tick();
    chk(line_q == 1'b1, "R7 active-low cke high holds", line_q, 1);
    cke = 1'b0; cfg_ie_low = 1'b1; ie = 1'b1;
    tick();
    chk(line_vld == 1'b0, "R7 active-low ie high disables", line_vld, 0);
    ie = 1'b0;
    tick();
    chk(line_vld == 1'b1 && line_q == 1'b0, "R7 active-low ie low enables", {line_q, line_vld}, 1);
    cfg_cke_low = 1'b0; cfg_ie_low = 1'b0; cke = 1'b1; ie = 1'b1;
  endtask

  task automatic t_fall();
    rst = 1'b1; cfg_fall = 1'b1; cfg_tap = '0;
    repeat (2) tick();
    rst = 1'b0; pin = 1'b0;
    tick();
    pin = 1'b1;
    @(posedge clk); #1;
    chk(line_q == 1'b0, "R6 rising edge ignored when fall selected", line_q, 0);
    @(negedge clk); #1;
    chk(line_q == 1'b1, "R6 falling edge captures", line_q, 1);
    rst = 1'b1; cfg_fall = 1'b0;
    repeat (2) tick();
    rst = 1'b0;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    t_pattern(3, 1'b0);
    t_pattern(7, 1'b1);
    t_pattern(0, 1'b1);
    t_hold();
    t_ie();
    t_polarity();
    t_fall();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule